// File: doc/BRIEF.md
# Banked Prioritized Interrupt Controller

This block collects interrupt requests from one to four banks of 32 lines each and steers every line to one of two processor outputs: a normal request (`irq_o`) or a fast request (`fiq_o`). For each line, software sets a 5-bit priority, a choice between edge and level capture, and a routing bit. A captured request takes part in arbitration when its mask bit is clear. The lowest priority value wins. When two candidates share a priority, the higher line number wins.

Each output has its own arbitration tree. Each output also has an "agreement" flag. When the flag is set and a candidate exists, the winning line number is frozen in a code register, the output goes high and the flag clears. The output then stays high, and the code stays frozen, until software writes the matching bit of the control register. Reading a code register returns the frozen line number. If that line is edge-captured, the read also retires its captured request.

The register interface is a plain 32-bit bus with address, write strobe, read strobe and write data. Read data is combinational. Address bits `[7:0]` pick a register and the bits above pick the bank.

Top module: `prio_intc`

## Requirements
- R1: After reset, both outputs are low, every mask register reads 0xFFFFFFFF, and every captured-request register, line configuration register and code register reads 0.
- R2: The line configuration register for line i of a bank sits at bank offset 0x1C + 4*i. Bit 0 is routing (1 = `fiq_o`, 0 = `irq_o`), bit 1 is capture mode (1 = level, 0 = edge) and bits [6:2] are the priority. Bits [31:7] read as zero.
- R3: An edge line is captured only on a low-to-high transition of its input. Holding the input high after the request is retired does not capture it again.
- R4: A level line is captured while its input is high, and its captured bit drops when the input falls. A write of 0 to the captured-request register (offset 0x00) does not clear a level line whose input is high.
- R5: A write to the captured-request register ANDs the written value into the captured bits.
- R6: The mask register (offset 0x04, 1 = blocked) is replaced by a write. A masked line never drives an output, and clearing its mask bit lets it drive one.
- R7: A candidate drives only the output selected by its routing bit.
- R8: Among candidates for one output, the lowest priority value wins. A tie goes to the highest line number across all banks.
- R9: Reading bank 0 offset 0x10 (normal) or 0x14 (fast) returns the frozen line number. That read retires the line's captured bit if the line is edge-captured, and leaves it in place if the line is level-captured.
- R10: An output rises at most once per agreement. It stays high, with its code unchanged, until a write to bank 0 offset 0x18 with bit 0 (normal) or bit 1 (fast) set. That write drops the output, and the output is then re-evaluated with the current candidates.
- R11: A write to offset 0x9C of a bank captures only the lowest set bit of the written value as a request of that bank.
- R12: Writes to the code registers are ignored. Offsets 0x10, 0x14 and 0x18 hold nothing outside bank 0. Every undefined offset, the control register and the software trigger register read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_lines | input | NBANK*32 | Request inputs, active high, line n at bit n |
| bus_addr | input | 8+BANK_W | Register address: bits [7:0] offset, upper bits bank |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (needed for code-read side effect) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |

## Verification
The hardest state to reach from the ports is a tie-break or priority decision involving lines in different banks. Whichever bank is unmasked first would otherwise claim the output before the rival request is visible. The stimulus therefore captures both competing requests through the software trigger while every line is still masked, and then unmasks both banks. It then writes both control acknowledge bits, which discards any early partial decision and forces one fresh arbitration over the full candidate set. The code read that follows is compared against the expected winner.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int unsigned LINES_PER_BANK = 32;
   localparam int unsigned PRIO_W         = 5;

   localparam logic [7:0] OFS_PEND     = 8'h00;
   localparam logic [7:0] OFS_MASK     = 8'h04;
   localparam logic [7:0] OFS_IRQ_CODE = 8'h10;
   localparam logic [7:0] OFS_FIQ_CODE = 8'h14;
   localparam logic [7:0] OFS_CTRL     = 8'h18;
   localparam logic [7:0] OFS_CFG_LO   = 8'h1C;
   localparam logic [7:0] OFS_CFG_HI   = 8'h98;
   localparam logic [7:0] OFS_SWTRIG   = 8'h9C;

   typedef enum logic {
      SINK_IRQ = 1'b0,
      SINK_FIQ = 1'b1
   } sink_e;
endpackage

// File: rtl/intc_bank.sv
module intc_bank
   import intc_pkg::*;
#(
   parameter int unsigned LINES = LINES_PER_BANK,
   parameter int unsigned PW    = PRIO_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [LINES-1:0]          line_in,
   input  logic                      acc_sel,
   input  logic [7:0]                acc_ofs,
   input  logic                      acc_we,
   input  logic [31:0]               acc_wdata,
   input  logic [LINES-1:0]          code_clr,
   output logic [LINES-1:0]          pend_o,
   output logic [LINES-1:0]          mask_o,
   output logic [LINES-1:0]          route_o,
   output logic [LINES-1:0][PW-1:0]  prio_o,
   output logic [31:0]               rdata_o
);
   localparam int unsigned IDX_W = $clog2(LINES);

   logic [LINES-1:0]         in_q, pend_q, mask_q, lvl_q, route_q;
   logic [LINES-1:0][PW-1:0] prio_q;
   logic [LINES-1:0]         edge_set, lvl_set, lvl_drop, sw_set, keep, pend_d;
   logic                     wr, cfg_hit;
   logic [IDX_W-1:0]         cfg_idx;

   assign wr      = acc_sel & acc_we;
   assign cfg_hit = (acc_ofs >= OFS_CFG_LO) && (acc_ofs <= OFS_CFG_HI) && (acc_ofs[1:0] == 2'b00);
   assign cfg_idx = IDX_W'((acc_ofs - OFS_CFG_LO) >> 2);

   always_comb begin
      edge_set = line_in & ~in_q & ~lvl_q;
      lvl_set  = line_in & lvl_q;
      lvl_drop = ~line_in & in_q & lvl_q;
      sw_set   = '0;
      if (wr && acc_ofs == OFS_SWTRIG)
         sw_set = LINES'(acc_wdata & (~acc_wdata + 32'd1));
      keep = '1;
      if (wr && acc_ofs == OFS_PEND)
         keep = LINES'(acc_wdata) | (line_in & lvl_q);
      pend_d = (pend_q & keep & ~lvl_drop & ~(code_clr & ~lvl_q))
               | edge_set | lvl_set | sw_set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_q    <= '0;
         pend_q  <= '0;
         mask_q  <= '1;
         lvl_q   <= '0;
         route_q <= '0;
         prio_q  <= '0;
      end else begin
         in_q   <= line_in;
         pend_q <= pend_d;
         if (wr && acc_ofs == OFS_MASK)
            mask_q <= LINES'(acc_wdata);
         if (wr && cfg_hit) begin
            prio_q[cfg_idx]  <= acc_wdata[PW+1:2];
            lvl_q[cfg_idx]   <= acc_wdata[1];
            route_q[cfg_idx] <= acc_wdata[0];
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      if (acc_sel) begin
         if (acc_ofs == OFS_PEND)
            rdata_o = 32'(pend_q);
         else if (acc_ofs == OFS_MASK)
            rdata_o = 32'(mask_q);
         else if (cfg_hit)
            rdata_o = 32'({prio_q[cfg_idx], lvl_q[cfg_idx], route_q[cfg_idx]});
      end
   end

   assign pend_o  = pend_q;
   assign mask_o  = mask_q;
   assign route_o = route_q;
   assign prio_o  = prio_q;

   // R3: a newly captured bit must come from a high input or a software trigger
   p_set_has_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q & ~$past(pend_q) & ~$past(line_in) & ~$past(sw_set)) == '0);

   // R4: a level line whose input just fell is no longer captured
   p_level_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q & $past(lvl_drop) & ~$past(sw_set)) == '0);
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
   parameter int unsigned N  = 64,
   parameter int unsigned PW = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N-1:0]           req_i,
   input  logic [N-1:0][PW-1:0]   prio_i,
   output logic                   win_valid_o,
   output logic [$clog2(N)-1:0]   win_idx_o
);
   localparam int unsigned LEVELS = $clog2(N);
   localparam int unsigned LEAVES = 1 << LEVELS;
   localparam int unsigned NODES  = 2 * LEAVES - 1;

   if (N < 2) begin : g_bad_n
      $error("intc_arbiter needs at least two requesters");
   end

   logic [LEAVES-1:0]         req_pad;
   logic [LEAVES-1:0][PW-1:0] prio_pad;

   if (LEAVES > N) begin : g_pad
      assign req_pad  = {{(LEAVES-N){1'b0}}, req_i};
      assign prio_pad = {{((LEAVES-N)*PW){1'b0}}, prio_i};
   end else begin : g_nopad
      assign req_pad  = req_i;
      assign prio_pad = prio_i;
   end

   logic [NODES-1:0]             nv;
   logic [NODES-1:0][PW-1:0]     np;
   logic [NODES-1:0][LEVELS-1:0] ni;

   // heap-ordered tree: right subtree holds higher line numbers and wins ties
   always_comb begin
      nv = '0;
      np = '0;
      ni = '0;
      for (int j = 0; j < LEAVES; j++) begin
         nv[LEAVES-1+j] = req_pad[j];
         np[LEAVES-1+j] = prio_pad[j];
         ni[LEAVES-1+j] = LEVELS'(j);
      end
      for (int k = LEAVES - 2; k >= 0; k--) begin
         if (nv[2*k+2] && (!nv[2*k+1] || np[2*k+2] <= np[2*k+1])) begin
            nv[k] = 1'b1;
            np[k] = np[2*k+2];
            ni[k] = ni[2*k+2];
         end else begin
            nv[k] = nv[2*k+1];
            np[k] = np[2*k+1];
            ni[k] = ni[2*k+1];
         end
      end
   end

   assign win_valid_o = nv[0];
   assign win_idx_o   = ni[0];

   // R8: the tree reports a winner exactly when some line requests
   p_valid_matches_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid_o == (|req_i));

   // R8: the reported winner is itself a requesting line
   p_winner_requests_r8: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid_o |-> req_i[win_idx_o]);
endmodule

// File: rtl/intc_agree.sv
module intc_agree #(
   parameter int unsigned IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             any_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic             ack_i,
   output logic             out_o,
   output logic [IDX_W-1:0] code_o
);
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         out_o   <= 1'b0;
         code_o  <= '0;
      end else if (ack_i) begin
         armed_q <= 1'b1;
         out_o   <= 1'b0;
      end else if (armed_q && any_i) begin
         armed_q <= 1'b0;
         out_o   <= 1'b1;
         code_o  <= idx_i;
      end
   end

   // R10: armed flag and asserted output are never both set or both clear
   p_armed_xor_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q != out_o);

   // R10: output drops only after an acknowledge
   p_fall_needs_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_o) |-> $past(ack_i));

   // R10: output rises only when a candidate existed
   p_rise_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_o) |-> $past(any_i));

   // R10: the frozen code holds while the output stays high
   p_code_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_o && $past(out_o)) |-> $stable(code_o));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
   import intc_pkg::*;
#(
   parameter int unsigned NBANK  = 2,
   localparam int unsigned BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
   localparam int unsigned ADDR_W = 8 + BANK_W,
   localparam int unsigned NLINES = NBANK * LINES_PER_BANK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] irq_lines,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_o,
   output logic              fiq_o
);
   localparam int unsigned CODE_W = $clog2(NLINES);

   if (NBANK < 1 || NBANK > 4) begin : g_bad_nbank
      $error("prio_intc: NBANK must be 1 to 4");
   end

   logic [BANK_W-1:0] bank_idx;
   logic [7:0]        ofs;
   logic              bank0;

   assign bank_idx = bus_addr[ADDR_W-1:8];
   assign ofs      = bus_addr[7:0];
   assign bank0    = (bank_idx == '0);

   logic [NLINES-1:0]              pend_all, mask_all, route_all, clr_all;
   logic [NLINES-1:0][PRIO_W-1:0]  prio_all;
   logic [NBANK-1:0][31:0]         bank_rd;
   logic [1:0]                     sink_out, ack;
   logic [1:0][CODE_W-1:0]         sink_code;
   logic                           code_rd_irq, code_rd_fiq;

   assign code_rd_irq = bus_re && bank0 && ofs == OFS_IRQ_CODE;
   assign code_rd_fiq = bus_re && bank0 && ofs == OFS_FIQ_CODE;
   assign ack         = (bus_we && bank0 && ofs == OFS_CTRL) ? bus_wdata[1:0] : 2'b00;

   always_comb begin
      clr_all = '0;
      if (code_rd_irq) clr_all[sink_code[SINK_IRQ]] = 1'b1;
      if (code_rd_fiq) clr_all[sink_code[SINK_FIQ]] = 1'b1;
   end

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic sel;
      assign sel = (bank_idx == BANK_W'(b));
      intc_bank #(.LINES(LINES_PER_BANK), .PW(PRIO_W)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .line_in   (irq_lines[b*LINES_PER_BANK +: LINES_PER_BANK]),
         .acc_sel   (sel),
         .acc_ofs   (ofs),
         .acc_we    (bus_we),
         .acc_wdata (bus_wdata),
         .code_clr  (clr_all[b*LINES_PER_BANK +: LINES_PER_BANK]),
         .pend_o    (pend_all[b*LINES_PER_BANK +: LINES_PER_BANK]),
         .mask_o    (mask_all[b*LINES_PER_BANK +: LINES_PER_BANK]),
         .route_o   (route_all[b*LINES_PER_BANK +: LINES_PER_BANK]),
         .prio_o    (prio_all[b*LINES_PER_BANK +: LINES_PER_BANK]),
         .rdata_o   (bank_rd[b])
      );
   end

   for (genvar s = 0; s < 2; s++) begin : g_sink
      logic [NLINES-1:0] req;
      logic              win_v;
      logic [CODE_W-1:0] win_i;
      if (s == int'(SINK_FIQ)) begin : g_fast
         assign req = pend_all & ~mask_all & route_all;
      end else begin : g_norm
         assign req = pend_all & ~mask_all & ~route_all;
      end
      intc_arbiter #(.N(NLINES), .PW(PRIO_W)) u_arb (
         .clk         (clk),
         .rst_n       (rst_n),
         .req_i       (req),
         .prio_i      (prio_all),
         .win_valid_o (win_v),
         .win_idx_o   (win_i)
      );
      intc_agree #(.IDX_W(CODE_W)) u_agree (
         .clk    (clk),
         .rst_n  (rst_n),
         .any_i  (win_v),
         .idx_i  (win_i),
         .ack_i  (ack[s]),
         .out_o  (sink_out[s]),
         .code_o (sink_code[s])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NBANK; b++)
         bus_rdata = bus_rdata | bank_rd[b];
      if (bank0 && ofs == OFS_IRQ_CODE) bus_rdata = 32'(sink_code[SINK_IRQ]);
      if (bank0 && ofs == OFS_FIQ_CODE) bus_rdata = 32'(sink_code[SINK_FIQ]);
   end

   assign irq_o = sink_out[SINK_IRQ];
   assign fiq_o = sink_out[SINK_FIQ];

   // R7: an output never rises while it has no routed, unmasked candidate
   p_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fiq_o) |-> $past(|(pend_all & ~mask_all & route_all)));
endmodule

// File: tb/prio_intc_test.sv
module prio_intc_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] lines = '0;
   logic [8:0]  addr = '0;
   logic        we = 1'b0, re = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq_o, fiq_o;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   prio_intc #(.NBANK(2)) uut (
      .clk(clk), .rst_n(rst_n), .irq_lines(lines), .bus_addr(addr),
      .bus_we(we), .bus_re(re), .bus_wdata(wdata), .bus_rdata(rdata),
      .irq_o(irq_o), .fiq_o(fiq_o)
   );

   typedef struct packed {
      logic [5:0] la; logic [4:0] pa;
      logic [5:0] lb; logic [4:0] pb;
      logic       fast;
      logic [5:0] exp;
   } vec_t;

   localparam vec_t VEC [7] = '{
      '{6'd3,  5'd5,  6'd40, 5'd2,  1'b0, 6'd40},
      '{6'd3,  5'd2,  6'd40, 5'd2,  1'b0, 6'd40},
      '{6'd10, 5'd7,  6'd12, 5'd7,  1'b1, 6'd12},
      '{6'd63, 5'd0,  6'd0,  5'd0,  1'b0, 6'd63},
      '{6'd5,  5'd1,  6'd33, 5'd9,  1'b1, 6'd5},
      '{6'd31, 5'd4,  6'd32, 5'd4,  1'b1, 6'd32},
      '{6'd20, 5'd31, 6'd2,  5'd30, 1'b0, 6'd2}
   };

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [8:0] a, logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(logic [8:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a; re = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      re = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; lines = '0; we = 1'b0; re = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(1);
   endtask

   function automatic logic [8:0] cfg_addr(int ln);
      return {1'(ln / 32), 8'(8'h1C + 4 * (ln % 32))};
   endfunction

   function automatic logic [8:0] trig_addr(int ln);
      return {1'(ln / 32), 8'h9C};
   endfunction

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
      end
   end

   initial begin
      logic [31:0] d;
      do_reset();

      // R1 reset state
      #1;
      chk("R1 irq_o", 32'(irq_o), 0);
      chk("R1 fiq_o", 32'(fiq_o), 0);
      rd(9'h004, d); chk("R1 mask bank0", d, 32'hFFFFFFFF);
      rd(9'h104, d); chk("R1 mask bank1", d, 32'hFFFFFFFF);
      rd(9'h000, d); chk("R1 pending", d, 0);
      rd(9'h030, d); chk("R1 config", d, 0);
      rd(9'h010, d); chk("R1 irq code", d, 0);
      rd(9'h014, d); chk("R1 fiq code", d, 0);

      // R2 config field layout
      wr(9'h138, 32'hFFFFFFFF);
      rd(9'h138, d); chk("R2 config width", d, 32'h7F);
      wr(9'h038, 32'h56);
      rd(9'h038, d); chk("R2 config fields", d, 32'h56);
      wr(9'h138, 0); wr(9'h038, 0);

      // R3 edge capture, R9 code read retires edge line
      wr(9'h004, 32'hFFFFFFEF);
      @(negedge clk) lines[4] = 1'b1;
      idle(3);
      rd(9'h000, d); chk("R3 edge captured", d, 32'h10);
      chk("R3 irq_o high", 32'(irq_o), 1);
      rd(9'h010, d); chk("R9 code edge", d, 4);
      rd(9'h000, d); chk("R9 edge retired", d, 0);
      wr(9'h018, 32'h1);
      idle(3);
      chk("R3 held input no recapture", 32'(irq_o), 0);
      @(negedge clk) lines[4] = 1'b0;
      idle(2);
      @(negedge clk) lines[4] = 1'b1;
      idle(3);
      chk("R3 new edge recaptures", 32'(irq_o), 1);
      rd(9'h010, d);
      wr(9'h018, 32'h1);
      @(negedge clk) lines[4] = 1'b0;

      // R4 level capture
      wr(9'h034, 32'h2);
      wr(9'h004, 32'hFFFFFFBF);
      @(negedge clk) lines[6] = 1'b1;
      idle(3);
      chk("R4 level irq_o", 32'(irq_o), 1);
      rd(9'h010, d); chk("R9 code level", d, 6);
      rd(9'h000, d); chk("R9 level kept after read", d, 32'h40);
      wr(9'h000, 0);
      rd(9'h000, d); chk("R4 write cannot clear active level", d, 32'h40);
      @(negedge clk) lines[6] = 1'b0;
      idle(2);
      rd(9'h000, d); chk("R4 level drops with input", d, 0);
      wr(9'h018, 32'h1);
      idle(3);
      chk("R4 no request after drop", 32'(irq_o), 0);

      // R11 software trigger, R5 pending AND, R6 mask
      wr(9'h09C, 32'h0E);
      rd(9'h000, d); chk("R11 lowest bit only", d, 32'h02);
      wr(9'h09C, 32'h08);
      wr(9'h09C, 32'h04);
      rd(9'h000, d); chk("R11 accumulated", d, 32'h0E);
      wr(9'h000, 32'hFFFFFFF5);
      rd(9'h000, d); chk("R5 AND write", d, 32'h04);
      idle(2);
      chk("R6 masked line silent", 32'(irq_o), 0);
      wr(9'h004, 32'hFFFFFFFB);
      idle(3);
      chk("R6 unmask asserts", 32'(irq_o), 1);
      rd(9'h010, d); chk("R6 code", d, 2);
      wr(9'h018, 32'h1);
      idle(3);
      chk("R6 retired", 32'(irq_o), 0);

      // R10 output and code held until acknowledge
      wr(cfg_addr(9), 32'h0C);
      wr(9'h004, 32'hFFFFFDFD);
      wr(trig_addr(9), 32'h200);
      idle(3);
      chk("R10 asserted", 32'(irq_o), 1);
      wr(trig_addr(1), 32'h2);
      idle(4);
      chk("R10 still high", 32'(irq_o), 1);
      rd(9'h010, d); chk("R10 code frozen", d, 9);
      wr(9'h018, 32'h1);
      idle(3);
      chk("R10 reasserts after ack", 32'(irq_o), 1);
      rd(9'h010, d); chk("R10 re-evaluated code", d, 1);
      wr(9'h018, 32'h1);
      idle(3);
      chk("R10 drops when empty", 32'(irq_o), 0);

      // R12 read-only and undefined offsets
      wr(9'h010, 32'h3F);
      rd(9'h010, d); chk("R12 code write ignored", d, 1);
      rd(9'h110, d); chk("R12 no code in bank1", d, 0);
      rd(9'h00C, d); chk("R12 undefined offset", d, 0);
      rd(9'h0A0, d); chk("R12 offset past trigger", d, 0);
      rd(9'h018, d); chk("R12 control reads zero", d, 0);
      rd(9'h09C, d); chk("R12 trigger reads zero", d, 0);

      // R7 / R8 arbitration table
      foreach (VEC[i]) begin
         vec_t v;
         v = VEC[i];
         do_reset();
         wr(cfg_addr(v.la), {25'd0, v.pa, 1'b0, v.fast});
         wr(cfg_addr(v.lb), {25'd0, v.pb, 1'b0, v.fast});
         wr(trig_addr(v.la), 32'd1 << (v.la % 32));
         wr(trig_addr(v.lb), 32'd1 << (v.lb % 32));
         wr(9'h004, 0);
         wr(9'h104, 0);
         wr(9'h018, 32'h3);
         idle(4);
         chk("R7 routed output", 32'(v.fast ? fiq_o : irq_o), 1);
         chk("R7 other output", 32'(v.fast ? irq_o : fiq_o), 0);
         rd(v.fast ? 9'h014 : 9'h010, d);
         chk("R8 winner", d, 32'(v.exp));
      end

      done = 1'b1;
      summary();
   end
endmodule